// File: doc/BRIEF.md
# Power-Fail Store/Recall Controller

This block sequences the copy operations between a static RAM array and its nonvolatile shadow cells. Two comparator flags come in from the supply monitor. One is high while the supply is above the switch threshold, and the other is high while the supply is above the lower reset threshold. The block also receives the SRAM write strobe and single-cycle software requests for a store or a recall. From these it starts store operations (erase, then program) and recall operations (clear, then transfer). It drives one phase indicator per step and a busy flag. While the supply is low, or while an operation runs, it withholds the write strobe from the array.

The controller starts an automatic store when the supply sinks below the switch threshold, but only if the array holds data written since the last nonvolatile operation. A recall is armed at reset and whenever the supply falls below the reset level. The armed recall runs once the supply climbs back over the switch threshold. A shallow brown-out therefore leaves the array untouched. Every duration is a parameter counted in clock cycles. Each operation splits its length in two: the first phase takes the floor of half the length, and the second phase takes the rest.

Top module: `pwrfail_nv_ctrl`

## Requirements
- R1: When `vcc_ok` is low, `vcc_alive` is high and no recall is armed, an automatic store starts only if an accepted write has occurred since the last completed store or recall; otherwise nothing starts.
- R2: A software store runs whether or not any write has occurred. It shows `st_erase` for STORE_CYC/2 cycles, then `st_program` for the remaining cycles.
- R3: A recall is armed by reset and by any cycle with `vcc_alive` low. The armed recall starts on the first idle cycle with `vcc_ok` high and runs `rc_clear` for PU_RECALL_CYC/2 cycles, then `rc_xfer` for the remaining cycles.
- R4: A drop of `vcc_ok` that keeps `vcc_alive` high performs no recall when `vcc_ok` returns.
- R5: While `vcc_ok` is low, `wr_allow` stays low and software store requests start nothing.
- R6: At most one phase output is high at a time. `store_start` and `recall_start` are single-cycle pulses that coincide with the first cycle of `st_erase` and `rc_clear` respectively. `busy` is high exactly while an operation runs.
- R7: A software recall runs `rc_clear` for SW_RECALL_CYC/2 cycles, then `rc_xfer` for the remaining cycles.
- R8: While `busy` is high, `wr_allow` stays low and software requests are ignored, not queued.
- R9: The written-since-last-operation state is set by each cycle with `wr_allow` high and cleared when any store or recall completes.
- R10: If `vcc_alive` goes low during an operation, the controller returns to idle on the next clock. It leaves the recall armed and the written state unchanged.
- R11: Priority among starts is armed recall first, then software recall, then software store. No automatic store starts while a recall is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Supply above the switch threshold |
| vcc_alive | input | 1 | Supply above the reset threshold |
| wr_req | input | 1 | SRAM write strobe from the host |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| wr_allow | output | 1 | Gated write strobe to the array |
| store_start | output | 1 | Store begins (first erase cycle) |
| recall_start | output | 1 | Recall begins (first clear cycle) |
| st_erase | output | 1 | Store phase: erase shadow cells |
| st_program | output | 1 | Store phase: program shadow cells |
| rc_clear | output | 1 | Recall phase: clear array |
| rc_xfer | output | 1 | Recall phase: transfer shadow to array |
| busy | output | 1 | Operation in progress, host access blocked |

## Verification
The bench builds the controller with STORE_CYC=8, PU_RECALL_CYC=6 and SW_RECALL_CYC=4. With these values every phase lasts only a few cycles, so each operation can be counted cycle by cycle against a split computed in the bench. With such short operations the bench can walk through every combination of clean or written array, shallow or deep supply dip, and software request, both while idle and while busy. It can also abort a store partway through erase and show that the armed recall survives.

// File: rtl/pfnv_pkg.sv
package pfnv_pkg;

   typedef enum logic [2:0] {
      NV_IDLE  = 3'd0,
      NV_ERASE = 3'd1,
      NV_PROG  = 3'd2,
      NV_CLEAR = 3'd3,
      NV_XFER  = 3'd4
   } nv_state_e;

   // first phase takes the floor of half the total, second phase the rest
   function automatic int unsigned head_len(input int unsigned total);
      return total / 2;
   endfunction

   function automatic int unsigned tail_len(input int unsigned total);
      return total - (total / 2);
   endfunction

endpackage

// File: rtl/pfnv_flag.sv
// Set/clear flag with a configurable reset value; set wins over clear.
module pfnv_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= RST_VAL;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/pfnv_seq.sv
// Operation sequencer: start arbitration, phase stepping and abort.
module pfnv_seq
   import pfnv_pkg::*;
#(
   parameter int unsigned STORE_CYC     = 1_250_000,
   parameter int unsigned PU_RECALL_CYC = 68_750,
   parameter int unsigned SW_RECALL_CYC = 2_500,
   parameter int unsigned CNT_W         = 21
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      vcc_ok,
   input  logic      vcc_alive,
   input  logic      pend_i,
   input  logic      dirty_i,
   input  logic      sw_store_req,
   input  logic      sw_recall_req,
   output nv_state_e state_o,
   output logic      store_start,
   output logic      recall_start,
   output logic      take_pend_o,
   output logic      done_o
);
   localparam int unsigned ST_HEAD = head_len(STORE_CYC);
   localparam int unsigned ST_TAIL = tail_len(STORE_CYC);
   localparam int unsigned PU_HEAD = head_len(PU_RECALL_CYC);
   localparam int unsigned PU_TAIL = tail_len(PU_RECALL_CYC);
   localparam int unsigned SW_HEAD = head_len(SW_RECALL_CYC);
   localparam int unsigned SW_TAIL = tail_len(SW_RECALL_CYC);

   nv_state_e  state;
   logic [CNT_W-1:0] cnt, tail_q;
   logic idle, last, go_pu, go_auto, go_swr, go_sws;

   assign idle    = (state == NV_IDLE);
   assign last    = (cnt == '0);
   assign go_pu   = idle & vcc_ok & vcc_alive & pend_i;
   assign go_auto = idle & ~vcc_ok & vcc_alive & dirty_i & ~pend_i;
   assign go_swr  = idle & vcc_ok & vcc_alive & ~pend_i & sw_recall_req;
   assign go_sws  = idle & vcc_ok & vcc_alive & ~pend_i & ~sw_recall_req & sw_store_req;

   assign take_pend_o = go_pu;
   assign done_o      = ((state == NV_PROG) | (state == NV_XFER)) & last & vcc_alive;
   assign state_o     = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= NV_IDLE;
         cnt          <= '0;
         tail_q       <= '0;
         store_start  <= 1'b0;
         recall_start <= 1'b0;
      end else begin
         store_start  <= go_auto | go_sws;
         recall_start <= go_pu | go_swr;
         if (idle) begin
            if (go_pu) begin
               state  <= NV_CLEAR;
               cnt    <= CNT_W'(PU_HEAD - 1);
               tail_q <= CNT_W'(PU_TAIL - 1);
            end else if (go_swr) begin
               state  <= NV_CLEAR;
               cnt    <= CNT_W'(SW_HEAD - 1);
               tail_q <= CNT_W'(SW_TAIL - 1);
            end else if (go_auto | go_sws) begin
               state  <= NV_ERASE;
               cnt    <= CNT_W'(ST_HEAD - 1);
               tail_q <= CNT_W'(ST_TAIL - 1);
            end
         end else if (!vcc_alive) begin
            state <= NV_IDLE;
            cnt   <= '0;
         end else if (!last) begin
            cnt <= cnt - 1'b1;
         end else begin
            unique case (state)
               NV_ERASE: begin state <= NV_PROG; cnt <= tail_q; end
               NV_CLEAR: begin state <= NV_XFER; cnt <= tail_q; end
               default:  state <= NV_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwrfail_nv_ctrl.sv
module pwrfail_nv_ctrl
   import pfnv_pkg::*;
#(
   parameter int unsigned STORE_CYC     = 1_250_000,
   parameter int unsigned PU_RECALL_CYC = 68_750,
   parameter int unsigned SW_RECALL_CYC = 2_500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_ok,
   input  logic vcc_alive,
   input  logic wr_req,
   input  logic sw_store_req,
   input  logic sw_recall_req,
   output logic wr_allow,
   output logic store_start,
   output logic recall_start,
   output logic st_erase,
   output logic st_program,
   output logic rc_clear,
   output logic rc_xfer,
   output logic busy
);
   localparam int unsigned MAX_CYC =
      (STORE_CYC > PU_RECALL_CYC) ?
         ((STORE_CYC > SW_RECALL_CYC) ? STORE_CYC : SW_RECALL_CYC) :
         ((PU_RECALL_CYC > SW_RECALL_CYC) ? PU_RECALL_CYC : SW_RECALL_CYC);
   localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

   if (STORE_CYC < 2) begin : g_bad_store
      $error("STORE_CYC must allow two phases of at least one cycle");
   end
   if (PU_RECALL_CYC < 2) begin : g_bad_pu
      $error("PU_RECALL_CYC must allow two phases of at least one cycle");
   end
   if (SW_RECALL_CYC < 2) begin : g_bad_sw
      $error("SW_RECALL_CYC must allow two phases of at least one cycle");
   end

   nv_state_e state;
   logic pend, dirty, take_pend, done;

   assign busy       = (state != NV_IDLE);
   assign st_erase   = (state == NV_ERASE);
   assign st_program = (state == NV_PROG);
   assign rc_clear   = (state == NV_CLEAR);
   assign rc_xfer    = (state == NV_XFER);
   assign wr_allow   = wr_req & vcc_ok & vcc_alive & ~busy;

   // armed-recall latch: reset arms it, a dip below the reset level re-arms it
   pfnv_flag #(.RST_VAL(1'b1)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .set_i(~vcc_alive), .clr_i(take_pend), .flag_o(pend)
   );

   // written-since-last-operation flag
   pfnv_flag #(.RST_VAL(1'b0)) u_dirty (
      .clk(clk), .rst_n(rst_n),
      .set_i(wr_allow), .clr_i(done), .flag_o(dirty)
   );

   pfnv_seq #(
      .STORE_CYC(STORE_CYC), .PU_RECALL_CYC(PU_RECALL_CYC),
      .SW_RECALL_CYC(SW_RECALL_CYC), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_alive(vcc_alive),
      .pend_i(pend), .dirty_i(dirty),
      .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
      .state_o(state), .store_start(store_start), .recall_start(recall_start),
      .take_pend_o(take_pend), .done_o(done)
   );
endmodule

// File: rtl/pfnv_checker.sv
module pfnv_checker (
   input logic clk,
   input logic rst_n,
   input logic vcc_ok,
   input logic vcc_alive,
   input logic busy,
   input logic store_start,
   input logic recall_start,
   input logic st_erase,
   input logic st_program,
   input logic rc_clear,
   input logic rc_xfer,
   input logic dirty,
   input logic pend
);
   assert_clean_no_autostore_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !vcc_ok && !dirty) |=> !store_start);

   assert_erase_then_program_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_erase && vcc_alive) |=> (st_erase || st_program));

   assert_armed_recall_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && vcc_ok && vcc_alive && pend) |=> (recall_start && rc_clear));

   assert_phase_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_erase, st_program, rc_clear, rc_xfer}));

   assert_store_start_in_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> st_erase);

   assert_recall_start_in_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      recall_start |-> rc_clear);

   assert_clear_then_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_clear && vcc_alive) |=> (rc_clear || rc_xfer));

   assert_abort_on_dip_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !vcc_alive) |=> !busy);
endmodule

bind pwrfail_nv_ctrl pfnv_checker u_pfnv_checker (
   .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_alive(vcc_alive),
   .busy(busy), .store_start(store_start), .recall_start(recall_start),
   .st_erase(st_erase), .st_program(st_program),
   .rc_clear(rc_clear), .rc_xfer(rc_xfer), .dirty(dirty), .pend(pend)
);

// File: tb/test_pwrfail_nv_ctrl.sv
module test_pwrfail_nv_ctrl;
   localparam int unsigned ST = 8, PU = 6, SW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic vcc_ok = 1'b0, vcc_alive = 1'b0, wr_req = 1'b0;
   logic sw_store_req = 1'b0, sw_recall_req = 1'b0;
   logic wr_allow, store_start, recall_start, st_erase, st_program, rc_clear, rc_xfer, busy;

   int checks = 0, errors = 0;
   int n_er, n_pr, n_cl, n_xf, n_ss, n_rs, n_bad;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pwrfail_nv_ctrl #(.STORE_CYC(ST), .PU_RECALL_CYC(PU), .SW_RECALL_CYC(SW)) i_pwrfail_nv_ctrl (
      .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .vcc_alive(vcc_alive), .wr_req(wr_req),
      .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req), .wr_allow(wr_allow),
      .store_start(store_start), .recall_start(recall_start), .st_erase(st_erase),
      .st_program(st_program), .rc_clear(rc_clear), .rc_xfer(rc_xfer), .busy(busy)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // counts phase cycles from the current negedge until busy drops
   task automatic observe();
      int guard = 0;
      n_er = 0; n_pr = 0; n_cl = 0; n_xf = 0; n_ss = 0; n_rs = 0; n_bad = 0;
      while (busy && guard < 200) begin
         n_er += int'(st_erase);   n_pr += int'(st_program);
         n_cl += int'(rc_clear);   n_xf += int'(rc_xfer);
         n_ss += int'(store_start); n_rs += int'(recall_start);
         if ((store_start && !st_erase) || (recall_start && !rc_clear)) n_bad++;
         if (int'(st_erase) + int'(st_program) + int'(rc_clear) + int'(rc_xfer) != 1) n_bad++;
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic expect_store(input string req, input int er, input int pr);
      observe();
      chk(req, "erase cycles", n_er, er);
      chk(req, "program cycles", n_pr, pr);
      chk(req, "store_start pulses", n_ss, 1);
      chk("R6", "phase/start mismatches", n_bad, 0);
      chk(req, "recall cycles", n_cl + n_xf, 0);
   endtask

   task automatic expect_recall(input string req, input int cl, input int xf);
      observe();
      chk(req, "clear cycles", n_cl, cl);
      chk(req, "transfer cycles", n_xf, xf);
      chk(req, "recall_start pulses", n_rs, 1);
      chk("R6", "phase/start mismatches", n_bad, 0);
      chk(req, "store cycles", n_er + n_pr, 0);
   endtask

   task automatic expect_none(input string req);
      observe();
      chk(req, "unexpected operation cycles", n_er + n_pr + n_cl + n_xf, 0);
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic do_write();
      wr_req = 1'b1; step(); wr_req = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      wr_req = 1'b1;
      repeat (3) step();
      chk("R6", "busy in reset", int'(busy), 0);
      chk("R5", "wr_allow in reset with supply low", int'(wr_allow), 0);
      rst_n = 1'b1; wr_req = 1'b0;

      // supply above reset level but below switch: recall armed, nothing runs
      vcc_alive = 1'b1; step(); step();
      expect_none("R11");
      // supply reaches switch threshold: power-up recall, head/tail split of PU
      vcc_ok = 1'b1; step();
      expect_recall("R3", PU / 2, PU - PU / 2);

      // accepted write while idle
      wr_req = 1'b1; #1;
      chk("R9", "wr_allow idle and supply good", int'(wr_allow), 1);
      step(); wr_req = 1'b0;

      // written array + drop below switch: automatic store
      vcc_ok = 1'b0; step();
      expect_store("R1", ST / 2, ST - ST / 2);
      // shallow brown-out returns: no recall
      vcc_ok = 1'b1; step();
      expect_none("R4");

      // software store with clean array still runs
      sw_store_req = 1'b1; step(); sw_store_req = 1'b0;
      expect_store("R2", ST / 2, ST - ST / 2);

      // clean array + drop: no automatic store
      vcc_ok = 1'b0; step();
      expect_none("R1");

      // low-voltage gating of writes and software store
      wr_req = 1'b1; #1;
      chk("R5", "wr_allow with supply below switch", int'(wr_allow), 0);
      step(); wr_req = 1'b0;
      sw_store_req = 1'b1; step(); sw_store_req = 1'b0;
      expect_none("R5");
      vcc_ok = 1'b1; step();
      expect_none("R4");
      vcc_ok = 1'b0; step();
      expect_none("R5");  // blocked write left array clean
      vcc_ok = 1'b1; step();

      // requests while busy are ignored
      sw_store_req = 1'b1; step(); sw_store_req = 1'b0;
      chk("R6", "busy after store request", int'(busy), 1);
      wr_req = 1'b1; sw_recall_req = 1'b1; #1;
      chk("R8", "wr_allow while busy", int'(wr_allow), 0);
      step(); wr_req = 1'b0; sw_recall_req = 1'b0;
      observe();
      chk("R8", "program cycles after busy requests", n_pr, ST - ST / 2);
      chk("R8", "recall cycles from ignored request", n_cl + n_xf + n_rs, 0);
      step();
      chk("R8", "busy after ignored recall request", int'(busy), 0);
      vcc_ok = 1'b0; step();
      expect_none("R8");  // write during busy did not mark array
      vcc_ok = 1'b1; step();

      // software recall, and it clears the written state
      do_write();
      sw_recall_req = 1'b1; step(); sw_recall_req = 1'b0;
      expect_recall("R7", SW / 2, SW - SW / 2);
      vcc_ok = 1'b0; step();
      expect_none("R9");
      vcc_ok = 1'b1; step();

      // both software requests together: recall wins
      sw_recall_req = 1'b1; sw_store_req = 1'b1; step();
      sw_recall_req = 1'b0; sw_store_req = 1'b0;
      expect_recall("R11", SW / 2, SW - SW / 2);

      // abort during erase
      do_write();
      vcc_ok = 1'b0; step();
      chk("R1", "erase after written drop", int'(st_erase), 1);
      step();
      vcc_alive = 1'b0; step();
      chk("R10", "busy after dip below reset", int'(busy), 0);
      vcc_alive = 1'b1; step(); step();
      expect_none("R11");  // written, but recall armed: no automatic store
      vcc_ok = 1'b1; step();
      expect_recall("R10", PU / 2, PU - PU / 2);
      vcc_ok = 1'b0; step();
      expect_none("R9");

      // deep brown-out without writes still recalls
      vcc_alive = 1'b0; step();
      vcc_alive = 1'b1; step();
      vcc_ok = 1'b1; step();
      expect_recall("R3", PU / 2, PU - PU / 2);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule